// File: doc/BRIEF.md
# Iterative Shift Multiply/Divide Unit

This block is an arithmetic helper that sits behind a narrow register write port and works out either an unsigned 8x8 product or an unsigned 16/8 quotient and remainder, one bit per enabled step. Software-side logic writes the operands through a select code. Writing the multiplier launches a multiply of eight steps. Writing the divisor launches a divide of sixteen steps. The same two result registers serve both operations. One holds the product or the remainder. The other holds the multiplier as it is consumed, or the quotient as it is built.

Every step is paced by a step-enable input, so the unit can be slowed or frozen. The result registers change in place on every step, so a read taken partway through returns a well-defined partial value, not a final answer. A divisor of zero gives an all-ones quotient and keeps the dividend as the remainder. A fresh launch while an operation is still running abandons that operation and starts over.

Top module: `shmd_unit`

## Requirements
- R1: While reset is held and after reset, `busy` is 0, `acc_out` is 0 and `qm_out` is 0.
- R2: A write with select code 1 starts a multiply. On the next cycle `acc_out` is 0, `qm_out` holds the written byte zero-extended, and `busy` is 1. The multiplicand is taken from the last select-0 write.
- R3: Each enabled multiply step does three things. It adds the shift register to `acc_out` when bit 0 of `qm_out` is 1. It shifts `qm_out` right by one. It shifts the shift register left by one. After eight steps `acc_out` equals multiplicand times multiplier.
- R4: A write with select code 4 starts a divide. On the next cycle `acc_out` holds the 16-bit dividend, `qm_out` is 0 and `busy` is 1. The dividend comes from select codes 2 (low byte) and 3 (high byte).
- R5: Each enabled divide step first shifts `qm_out` left by one and the shift register (initially the divisor times 65536) right by one. When `acc_out` is at least the shift register, it then subtracts the shift register and sets bit 0 of `qm_out`. After sixteen steps `qm_out` is the quotient and `acc_out` the remainder.
- R6: With a zero divisor the divide ends with `qm_out` = 0xFFFF and `acc_out` = the dividend.
- R7: Partial values are observable. After k multiply steps, `acc_out` = multiplicand x (multiplier mod 2^k) and `qm_out` = multiplier >> k. After k divide steps with a nonzero divisor d, `qm_out` = dividend / (d x 2^(16-k)) and `acc_out` = dividend mod (d x 2^(16-k)).
- R8: When `step_en` is low, or no operation is pending, a cycle without a launch leaves `acc_out`, `qm_out` and `busy` unchanged.
- R9: A launch while busy restarts from the new operands. A launch in the same cycle as `step_en` takes priority, and no step is applied in that cycle.
- R10: Writes with select codes 0, 2, 3 and 5 to 7 never change `acc_out`, `qm_out` or an operation already in progress.
- R11: `busy` stays 1 until the last step of the operation has been applied and drops on the following cycle. Only one operation is in progress at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 3 | Write target: 0 multiplicand, 1 multiplier and launch, 2 dividend low, 3 dividend high, 4 divisor and launch |
| wr_data | input | 8 | Write data byte |
| step_en | input | 1 | Permits one step in this cycle |
| busy | output | 1 | An operation has steps remaining |
| acc_out | output | 16 | Product (multiply) or remainder (divide) |
| qm_out | output | 16 | Remaining multiplier (multiply) or quotient (divide) |

## Verification
Several properties are checked on every cycle. A launch loads the registers and raises `busy`. A multiply step halves the multiplier register. A divide step shifts the quotient left and sets its new bit whenever a subtraction is taken. The remainder never grows during a divide. Idle cycles freeze the outputs, and the two step counters are never active together. Arithmetic correctness of products, quotients and the partial values after an arbitrary number of stalled steps can only be shown by the bench's scenarios, as can divide-by-zero, restart and operand-write isolation.

// File: rtl/shmd_pkg.sv
package shmd_pkg;

  typedef enum logic [2:0] {
    SEL_MCAND  = 3'd0,
    SEL_MPLIER = 3'd1,
    SEL_DVD_LO = 3'd2,
    SEL_DVD_HI = 3'd3,
    SEL_DIVSR  = 3'd4
  } wr_sel_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2
  } op_e;

endpackage

// File: rtl/shmd_operands.sv
module shmd_operands
  import shmd_pkg::*;
#(
  parameter int OPW = 8,
  localparam int DW = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [OPW-1:0] wr_data,
  output logic [OPW-1:0] mcand,
  output logic [DW-1:0]  dividend,
  output logic [OPW-1:0] launch_val,
  output logic           start_mul,
  output logic           start_div
);

  logic [OPW-1:0] mcand_q;
  logic [DW-1:0]  dvd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q <= '0;
      dvd_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MCAND:  mcand_q          <= wr_data;
        SEL_DVD_LO: dvd_q[OPW-1:0]   <= wr_data;
        SEL_DVD_HI: dvd_q[DW-1:OPW]  <= wr_data;
        default: ;
      endcase
    end
  end

  // launch decode: a write to the second operand begins the operation
  assign start_mul  = wr_en && (wr_sel == SEL_MPLIER);
  assign start_div  = wr_en && (wr_sel == SEL_DIVSR);
  assign launch_val = wr_data;
  assign mcand      = mcand_q;
  assign dividend   = dvd_q;

endmodule

// File: rtl/shmd_sequencer.sv
module shmd_sequencer
  import shmd_pkg::*;
#(
  parameter int OPW = 8,
  localparam int DW     = 2 * OPW,
  localparam int MSTEPS = OPW,
  localparam int DSTEPS = DW,
  localparam int CW     = $clog2(DSTEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_mul,
  input  logic          start_div,
  input  logic          step_en,
  output logic          mul_fire,
  output logic          div_fire,
  output logic          busy,
  output logic [CW-1:0] mcnt,
  output logic [CW-1:0] dcnt,
  output op_e           op_now
);

  logic [CW-1:0] mcnt_q, dcnt_q;
  logic          launch;

  assign launch = start_mul || start_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt_q <= '0;
      dcnt_q <= '0;
    end else if (start_mul) begin
      mcnt_q <= CW'(MSTEPS);
      dcnt_q <= '0;
    end else if (start_div) begin
      dcnt_q <= CW'(DSTEPS);
      mcnt_q <= '0;
    end else if (step_en) begin
      if (mcnt_q != '0) mcnt_q <= mcnt_q - 1'b1;
      if (dcnt_q != '0) dcnt_q <= dcnt_q - 1'b1;
    end
  end

  always_comb begin
    op_now = OP_NONE;
    if (mcnt_q != '0)      op_now = OP_MUL;
    else if (dcnt_q != '0) op_now = OP_DIV;
  end

  assign mul_fire = step_en && !launch && (op_now == OP_MUL);
  assign div_fire = step_en && !launch && (op_now == OP_DIV);
  assign busy     = (op_now != OP_NONE);
  assign mcnt     = mcnt_q;
  assign dcnt     = dcnt_q;

endmodule

// File: rtl/shmd_datapath.sv
module shmd_datapath #(
  parameter int OPW = 8,
  localparam int DW = 2 * OPW,
  localparam int SW = DW + OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_mul,
  input  logic           start_div,
  input  logic           mul_fire,
  input  logic           div_fire,
  input  logic [OPW-1:0] mcand,
  input  logic [DW-1:0]  dividend,
  input  logic [OPW-1:0] launch_val,
  output logic           div_take,
  output logic [DW-1:0]  acc,
  output logic [DW-1:0]  qm
);

  logic [DW-1:0] acc_q, qm_q;
  logic [SW-1:0] shf_q;

  // multiply: conditional accumulate of the running shifted multiplicand
  function automatic logic [DW-1:0] f_mul_acc(input logic [DW-1:0] a,
                                              input logic [SW-1:0] s,
                                              input logic          bit0);
    return bit0 ? a + s[DW-1:0] : a;
  endfunction

  // divide: does the trial subtraction fit
  function automatic logic f_div_fits(input logic [DW-1:0] r,
                                      input logic [SW-1:0] s);
    return {{OPW{1'b0}}, r} >= s;
  endfunction

  function automatic logic [DW-1:0] f_div_rem(input logic [DW-1:0] r,
                                              input logic [SW-1:0] s,
                                              input logic          fits);
    return fits ? r - s[DW-1:0] : r;
  endfunction

  logic [DW-1:0] acc_mul, qm_mul, acc_div, qm_div;
  logic [SW-1:0] shf_mul, shf_div;

  always_comb begin
    acc_mul  = f_mul_acc(acc_q, shf_q, qm_q[0]);
    qm_mul   = qm_q >> 1;
    shf_mul  = shf_q << 1;
    shf_div  = shf_q >> 1;
    div_take = f_div_fits(acc_q, shf_div);
    acc_div  = f_div_rem(acc_q, shf_div, div_take);
    qm_div   = {qm_q[DW-2:0], div_take};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      qm_q  <= '0;
      shf_q <= '0;
    end else if (start_mul) begin
      acc_q <= '0;
      qm_q  <= DW'(launch_val);
      shf_q <= SW'(mcand);
    end else if (start_div) begin
      acc_q <= dividend;
      qm_q  <= '0;
      shf_q <= {launch_val, {DW{1'b0}}};
    end else if (mul_fire) begin
      acc_q <= acc_mul;
      qm_q  <= qm_mul;
      shf_q <= shf_mul;
    end else if (div_fire) begin
      acc_q <= acc_div;
      qm_q  <= qm_div;
      shf_q <= shf_div;
    end
  end

  assign acc = acc_q;
  assign qm  = qm_q;

endmodule

// File: rtl/shmd_unit.sv
module shmd_unit
  import shmd_pkg::*;
#(
  parameter int OPW = 8,
  localparam int DW = 2 * OPW,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [OPW-1:0] wr_data,
  input  logic           step_en,
  output logic           busy,
  output logic [DW-1:0]  acc_out,
  output logic [DW-1:0]  qm_out
);

  logic [OPW-1:0] mcand, launch_val;
  logic [DW-1:0]  dividend;
  logic           start_mul, start_div;
  logic           mul_fire, div_fire, div_take;
  logic [CW-1:0]  mcnt, dcnt;
  op_e            op_now;

  shmd_operands #(.OPW(OPW)) u_opnd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .mcand(mcand), .dividend(dividend),
    .launch_val(launch_val), .start_mul(start_mul), .start_div(start_div)
  );

  shmd_sequencer #(.OPW(OPW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_mul(start_mul), .start_div(start_div),
    .step_en(step_en), .mul_fire(mul_fire), .div_fire(div_fire),
    .busy(busy), .mcnt(mcnt), .dcnt(dcnt), .op_now(op_now)
  );

  shmd_datapath #(.OPW(OPW)) u_dp (
    .clk(clk), .rst_n(rst_n), .start_mul(start_mul), .start_div(start_div),
    .mul_fire(mul_fire), .div_fire(div_fire), .mcand(mcand),
    .dividend(dividend), .launch_val(launch_val), .div_take(div_take),
    .acc(acc_out), .qm(qm_out)
  );

endmodule

// File: rtl/shmd_checker.sv
module shmd_checker #(
  parameter int DW = 16,
  parameter int CW = 5,
  parameter int MSTEPS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          step_en,
  input logic          busy,
  input logic [DW-1:0] acc_out,
  input logic [DW-1:0] qm_out,
  input logic          start_mul,
  input logic          start_div,
  input logic          mul_fire,
  input logic          div_fire,
  input logic          div_take,
  input logic [CW-1:0] mcnt,
  input logic [CW-1:0] dcnt
);

  p_mul_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_mul |=> (busy && acc_out == '0));

  p_div_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_div |=> (busy && qm_out == '0));

  p_mul_halve_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> (qm_out == ($past(qm_out) >> 1)));

  p_div_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_fire |=> (qm_out[DW-1:1] == $past(qm_out[DW-2:0])));

  p_div_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_fire && div_take) |=> qm_out[0]);

  p_rem_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_fire |=> (acc_out <= $past(acc_out)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !step_en) |=> ($stable(acc_out) && $stable(qm_out) && $stable(busy)));

  p_single_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mcnt != '0, dcnt != '0}));

  p_mcnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt <= CW'(MSTEPS));

endmodule

bind shmd_unit shmd_checker #(.DW(DW), .CW(CW), .MSTEPS(OPW)) i_shmd_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .step_en(step_en), .busy(busy),
  .acc_out(acc_out), .qm_out(qm_out), .start_mul(start_mul),
  .start_div(start_div), .mul_fire(mul_fire), .div_fire(div_fire),
  .div_take(div_take), .mcnt(mcnt), .dcnt(dcnt)
);

// File: tb/test_shmd_unit.sv
`timescale 1ns/1ps
module test_shmd_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        step_en = 1'b0;
  logic        busy;
  logic [15:0] acc_out, qm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shmd_unit i_shmd_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .step_en(step_en), .busy(busy),
    .acc_out(acc_out), .qm_out(qm_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mul_acc(int a, int b, int k);
    return (a * (b & ((1 << k) - 1))) & 32'hFFFF;
  endfunction
  function automatic logic [31:0] exp_mul_qm(int b, int k);
    return b >> k;
  endfunction
  function automatic logic [31:0] exp_div_qm(int n, int d, int k);
    longint den;
    if (d == 0) return (1 << k) - 1;
    den = longint'(d) << (16 - k);
    return 32'(n / den);
  endfunction
  function automatic logic [31:0] exp_div_acc(int n, int d, int k);
    longint den;
    if (d == 0) return n;
    den = longint'(d) << (16 - k);
    return 32'(n % den);
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // apply k effective steps with random stall cycles
  task automatic run_steps(input int k, input bit stall);
    int cnt = 0;
    while (cnt < k) begin
      step_en = stall ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
      if (step_en) cnt++;
    end
    step_en = 1'b0;
  endtask

  task automatic start_mul(input int a, input int b);
    wr(3'd0, 8'(a));
    wr(3'd1, 8'(b));
  endtask

  task automatic start_div(input int n, input int d);
    wr(3'd2, 8'(n));
    wr(3'd3, 8'(n >> 8));
    wr(3'd4, 8'(d));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 0);
    chk("R1 acc in reset", 32'(acc_out), 0);
    chk("R1 qm in reset", 32'(qm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 0);

    // directed multiply 0xFF x 0xFF
    start_mul(255, 255);
    chk("R2 acc load", 32'(acc_out), 0);
    chk("R2 qm load", 32'(qm_out), 32'h00FF);
    chk("R2 busy", 32'(busy), 1);
    run_steps(7, 1'b0);
    chk("R7 mul partial acc", 32'(acc_out), exp_mul_acc(255, 255, 7));
    chk("R11 busy before last step", 32'(busy), 1);
    run_steps(1, 1'b0);
    chk("R3 product", 32'(acc_out), 32'hFE01);
    chk("R3 qm empty", 32'(qm_out), 0);
    chk("R11 busy dropped", 32'(busy), 0);
    run_steps(3, 1'b0);
    chk("R8 idle steps acc", 32'(acc_out), 32'hFE01);
    chk("R8 idle steps busy", 32'(busy), 0);

    // directed divides
    start_div(16'hFFFF, 1);
    chk("R4 acc load", 32'(acc_out), 32'hFFFF);
    chk("R4 qm load", 32'(qm_out), 0);
    chk("R4 busy", 32'(busy), 1);
    run_steps(16, 1'b0);
    chk("R5 quotient by one", 32'(qm_out), 32'hFFFF);
    chk("R5 remainder by one", 32'(acc_out), 0);
    chk("R11 busy after divide", 32'(busy), 0);
    start_div(16'd1234, 0);
    run_steps(5, 1'b0);
    chk("R6 partial qm zero divisor", 32'(qm_out), 32'h001F);
    run_steps(11, 1'b0);
    chk("R6 qm zero divisor", 32'(qm_out), 32'hFFFF);
    chk("R6 acc zero divisor", 32'(acc_out), 32'd1234);
    start_div(16'd1000, 7);
    run_steps(16, 1'b0);
    chk("R5 1000/7 q", 32'(qm_out), 32'd142);
    chk("R5 1000/7 r", 32'(acc_out), 32'd6);

    // R10: operand writes during a multiply do not disturb it
    start_mul(8'hA5, 8'h3C);
    run_steps(3, 1'b0);
    wr(3'd0, 8'h11);
    wr(3'd2, 8'h22);
    wr(3'd3, 8'h33);
    wr(3'd6, 8'h44);
    chk("R10 acc held", 32'(acc_out), exp_mul_acc(8'hA5, 8'h3C, 3));
    chk("R10 qm held", 32'(qm_out), exp_mul_qm(8'h3C, 3));
    run_steps(5, 1'b0);
    chk("R10 product intact", 32'(acc_out), 32'(8'hA5 * 8'h3C));

    // R9: restart with divide mid-multiply, and launch wins over step
    wr(3'd0, 8'd9);
    wr(3'd1, 8'd13);
    run_steps(2, 1'b0);
    start_div(16'd500, 3);
    chk("R9 restart acc", 32'(acc_out), 32'd500);
    chk("R9 restart qm", 32'(qm_out), 0);
    run_steps(4, 1'b0);
    @(negedge clk);
    step_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'd77;
    @(negedge clk);
    step_en = 1'b0; wr_en = 1'b0;
    chk("R9 launch priority qm", 32'(qm_out), 32'd77);
    chk("R9 launch priority acc", 32'(acc_out), 0);
    run_steps(8, 1'b1);
    chk("R9 restarted product", 32'(acc_out), 32'(9 * 77));

    // constrained random mix
    for (int it = 0; it < 150; it++) begin
      bit is_div = 1'($urandom % 2);
      if (!is_div) begin
        int a = int'($urandom % 256);
        int b = int'($urandom % 256);
        int k = int'($urandom % 9);
        start_mul(a, b);
        run_steps(k, 1'b1);
        chk("R7 rand mul acc", 32'(acc_out), exp_mul_acc(a, b, k));
        chk("R7 rand mul qm", 32'(qm_out), exp_mul_qm(b, k));
        run_steps(8 - k, 1'b1);
        chk("R3 rand product", 32'(acc_out), exp_mul_acc(a, b, 8));
        chk("R11 rand mul busy", 32'(busy), 0);
      end else begin
        int n = int'($urandom % 65536);
        int d = (it % 10 == 0) ? 0 : int'($urandom % 256);
        int k = int'($urandom % 17);
        start_div(n, d);
        run_steps(k, 1'b1);
        chk("R7 rand div qm", 32'(qm_out), exp_div_qm(n, d, k));
        chk("R7 rand div acc", 32'(acc_out), exp_div_acc(n, d, k));
        run_steps(16 - k, 1'b1);
        chk("R5 rand quotient", 32'(qm_out), exp_div_qm(n, d, 16));
        chk("R5 rand remainder", 32'(acc_out), exp_div_acc(n, d, 16));
        chk("R11 rand div busy", 32'(busy), 0);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule